// File: doc/BRIEF.md
# Paralleled Boost Current Loop Controller

This block computes the duty command for a power factor correction stage built from two boost channels running in parallel. Each time the control sequencer issues a start strobe, the block takes the two sampled switch currents, the current set point handed down by the outer voltage loop and the sampled rectified mains voltage. It then produces one duty word that is applied to both channels.

The control law is a proportional-integral term on the current error plus a feedforward term. The feedback value is the larger of the two channel currents. The feedforward is the mains sample multiplied by a programmable constant that stands for the reciprocal of the DC link set point, so no run-time division is needed. The result is clamped between zero and 80 % of full scale. While the output is clamped, the integrator does not accumulate.

Gains are signed fixed-point words with 8 fraction bits. They are written through a small configuration port and are only accepted while no computation is in flight. The duty word is an unsigned fraction of full scale: a value d means d / 2^DUTY_W.

Top module: `pfc_cur_loop`

## Requirements
- R1: The feedback value is the signed maximum of the two switch current samples; swapping the two samples does not change the result.
- R2: With e = iref − max(isw_a, isw_b) (signed, DW+1 bits), the unclamped duty is floor((Kp·e + W' + Kff·vin) / 256), where W' = W + Ki·e is the integrator state including this step's increment and gains carry 8 fraction bits.
- R3: Every unclamped computation stores W' as the new integrator state, so a constant error makes the duty grow by the same step on each computation.
- R4: The duty output never exceeds DUTY_MAX = floor(0.8·2^DUTY_W) (3276 for DUTY_W = 12); larger unclamped values give exactly DUTY_MAX.
- R5: A negative unclamped duty gives a duty output of 0.
- R6: When the unclamped duty lies outside [0, DUTY_MAX], the integrator keeps its previous value (anti-windup).
- R7: A start accepted at rising edge k makes duty_vld_o high for exactly one cycle, starting at edge k+3, with the new duty on duty_o; duty_o holds its value at all other times.
- R8: A start strobe that arrives while a computation is in flight is ignored and yields no extra result.
- R9: A configuration write selects Kp with code 0, Ki with code 1 and Kff with code 2 (code 3 writes nothing). It takes effect only when no computation is in flight and start is low; otherwise it is dropped.
- R10: After reset, duty_o = 0, duty_vld_o = 0, the integrator is 0 and the gains are Kp = 960 (3.75), Ki = 64 (12500 × 1/50000 = 0.25) and Kff = 128 (0.5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launches one control computation |
| isw_a_i | input | DW | Switch current sample, channel A (signed) |
| isw_b_i | input | DW | Switch current sample, channel B (signed) |
| iref_i | input | DW | Current set point (signed) |
| vin_i | input | DW | Rectified mains voltage sample (signed) |
| cfg_we_i | input | 1 | Gain write strobe |
| cfg_sel_i | input | 2 | Gain select: 0 Kp, 1 Ki, 2 Kff |
| cfg_data_i | input | GW | Gain value, signed, 8 fraction bits |
| duty_o | output | DUTY_W | Duty command for both boost channels |
| duty_vld_o | output | 1 | One-cycle pulse marking a new duty_o |

## Verification
A grid sweep covers every pairing of six current values, including both extremes, zero and ±1, against several set points and mains samples. This sweep separates a correct maximum from a minimum or a one-channel feedback, and it drives the output through the unclamped region and both clamps while the integrator carries its state across the whole run. Directed runs with only the integral gain set show the constant per-step growth. They also show that the integrator holds, not winds, once the output has saturated. Extra strobes and gain writes placed during a computation, and in the start cycle itself, show whether the sequencing and the write gating are at fault or the arithmetic.

// File: rtl/pfc_cl_pkg.sv
// Package: shared codes for the paralleled boost current loop.
// Assumes: gain words are signed with a fixed number of fraction bits.
package pfc_cl_pkg;
    // Gain register selection codes on the configuration port.
    typedef enum logic [1:0] {
        GSEL_KP   = 2'd0,
        GSEL_KI   = 2'd1,
        GSEL_KFF  = 2'd2,
        GSEL_NONE = 2'd3
    } gain_sel_e;
endpackage

// File: rtl/pfc_fb_max.sv
// Module: picks the signed maximum of N packed channel samples.
// Assumes: N >= 1, samples are two's complement of W bits each.
module pfc_fb_max #(
    parameter int N = 2,
    parameter int W = 12
) (
    input  logic [N*W-1:0]        bus_i,
    output logic signed [W-1:0]   max_o
);
    // Linear scan over the channels keeps the larger value.
    always_comb begin
        max_o = $signed(bus_i[W-1:0]);
        for (int k = 1; k < N; k++) begin
            if ($signed(bus_i[k*W +: W]) > max_o) begin
                max_o = $signed(bus_i[k*W +: W]);
            end
        end
    end
endmodule

// File: rtl/pfc_gain_regs.sv
// Module: holds the three loop gains, written through the config port.
// Assumes: the caller gates writes with the idle condition.
module pfc_gain_regs
    import pfc_cl_pkg::*;
#(
    parameter int GW       = 16,
    parameter int KP_INIT  = 960,
    parameter int KI_INIT  = 64,
    parameter int KFF_INIT = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [1:0]           wr_sel_i,
    input  logic signed [GW-1:0] wr_data_i,
    output logic signed [GW-1:0] kp_o,
    output logic signed [GW-1:0] ki_o,
    output logic signed [GW-1:0] kff_o
);
    // Register update: reset to defaults, otherwise load the selected gain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kp_o  <= GW'(KP_INIT);
            ki_o  <= GW'(KI_INIT);
            kff_o <= GW'(KFF_INIT);
        end else if (wr_en_i) begin
            case (gain_sel_e'(wr_sel_i))
                GSEL_KP:  kp_o  <= wr_data_i;
                GSEL_KI:  ki_o  <= wr_data_i;
                GSEL_KFF: kff_o <= wr_data_i;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/pfc_law_core.sv
// Module: two pipeline stages of the control law.
//   Stage A: the three products (Kp*e, Ki*e, Kff*vin).
//   Stage B: candidate integrator W+Ki*e and the full unclamped sum.
// Assumes: only one computation is in flight, so integ_i is settled.
module pfc_law_core #(
    parameter int EW    = 13,
    parameter int DW    = 12,
    parameter int GW    = 16,
    parameter int ACC_W = 33
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld_i,
    input  logic signed [EW-1:0]    err_i,
    input  logic signed [DW-1:0]    vin_i,
    input  logic signed [GW-1:0]    kp_i,
    input  logic signed [GW-1:0]    ki_i,
    input  logic signed [GW-1:0]    kff_i,
    input  logic signed [ACC_W-1:0] integ_i,
    output logic                    mid_vld_o,
    output logic                    out_vld_o,
    output logic signed [ACC_W-1:0] sum_o,
    output logic signed [ACC_W-1:0] cand_o
);
    logic signed [ACC_W-1:0] err_x, vin_x, kp_x, ki_x, kff_x;
    logic signed [ACC_W-1:0] p_q, inc_q, ff_q;

    // Sign-extend every operand to the accumulator width.
    always_comb begin
        err_x = ACC_W'(err_i);
        vin_x = ACC_W'(vin_i);
        kp_x  = ACC_W'(kp_i);
        ki_x  = ACC_W'(ki_i);
        kff_x = ACC_W'(kff_i);
    end

    // Stage A: register the three products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_vld_o <= 1'b0;
            p_q       <= '0;
            inc_q     <= '0;
            ff_q      <= '0;
        end else begin
            mid_vld_o <= in_vld_i;
            if (in_vld_i) begin
                p_q   <= kp_x * err_x;
                inc_q <= ki_x * err_x;
                ff_q  <= kff_x * vin_x;
            end
        end
    end

    // Stage B: register the integrator candidate and the unclamped sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld_o <= 1'b0;
            sum_o     <= '0;
            cand_o    <= '0;
        end else begin
            out_vld_o <= mid_vld_o;
            if (mid_vld_o) begin
                cand_o <= integ_i + inc_q;
                sum_o  <= p_q + integ_i + inc_q + ff_q;
            end
        end
    end
endmodule

// File: rtl/pfc_duty_clamp.sv
// Module: scales the sum down by the gain fraction bits and clamps it.
// Assumes: 0 < DUTY_MAX < 2**DUTY_W; floor scaling (arithmetic shift).
module pfc_duty_clamp #(
    parameter int ACC_W    = 33,
    parameter int GF       = 8,
    parameter int DUTY_W   = 12,
    parameter int DUTY_MAX = 3276
) (
    input  logic signed [ACC_W-1:0] sum_i,
    output logic [DUTY_W-1:0]       duty_o,
    output logic                    sat_o
);
    localparam logic signed [ACC_W-1:0] DMAX_S = ACC_W'(DUTY_MAX);
    logic signed [ACC_W-1:0] scaled;

    // Scale, then select the lower bound, the upper bound or the value.
    always_comb begin
        scaled = sum_i >>> GF;
        if (scaled < 0) begin
            duty_o = '0;
            sat_o  = 1'b1;
        end else if (scaled > DMAX_S) begin
            duty_o = DUTY_W'(DUTY_MAX);
            sat_o  = 1'b1;
        end else begin
            duty_o = scaled[DUTY_W-1:0];
            sat_o  = 1'b0;
        end
    end
endmodule

// File: rtl/pfc_cur_loop.sv
// Module: current loop for two paralleled boost channels.
//   edge k   : start accepted, error and mains sample registered
//   edge k+1 : products
//   edge k+2 : integrator candidate and sum
//   edge k+3 : clamped duty out, valid pulse, integrator commit
// Assumes: one computation at a time; gains change only while idle.
module pfc_cur_loop
    import pfc_cl_pkg::*;
#(
    parameter int DW       = 12,
    parameter int GW       = 16,
    parameter int GF       = 8,
    parameter int DUTY_W   = 12,
    parameter int DMAX_NUM = 4,
    parameter int DMAX_DEN = 5,
    parameter int KP_INIT  = 960,
    parameter int KI_INIT  = 64,
    parameter int KFF_INIT = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic signed [DW-1:0] isw_a_i,
    input  logic signed [DW-1:0] isw_b_i,
    input  logic signed [DW-1:0] iref_i,
    input  logic signed [DW-1:0] vin_i,
    input  logic                 cfg_we_i,
    input  logic [1:0]           cfg_sel_i,
    input  logic signed [GW-1:0] cfg_data_i,
    output logic [DUTY_W-1:0]    duty_o,
    output logic                 duty_vld_o
);
    localparam int NCH      = 2;
    localparam int EW       = DW + 1;
    localparam int ACC_W    = EW + GW + 4;
    localparam int DUTY_MAX = (DMAX_NUM * (2 ** DUTY_W)) / DMAX_DEN;

    logic                    s1_v, s2_v, s3_v, busy, start_ok, cfg_ok;
    logic signed [DW-1:0]    fb_c, vin_q;
    logic signed [EW-1:0]    err_c, err_q, ref_x, fb_x;
    logic signed [GW-1:0]    kp_q, ki_q, kff_q;
    logic signed [ACC_W-1:0] integ_q, sum_q, cand_q;
    logic [DUTY_W-1:0]       duty_c;
    logic                    sat_c;

    // Sequencing: a computation is in flight while any stage holds data.
    always_comb begin
        busy     = s1_v | s2_v | s3_v;
        start_ok = start_i & ~busy;
        cfg_ok   = cfg_we_i & ~busy & ~start_i;
    end

    pfc_gain_regs #(
        .GW(GW), .KP_INIT(KP_INIT), .KI_INIT(KI_INIT), .KFF_INIT(KFF_INIT)
    ) u_gains (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(cfg_ok), .wr_sel_i(cfg_sel_i), .wr_data_i(cfg_data_i),
        .kp_o(kp_q), .ki_o(ki_q), .kff_o(kff_q)
    );

    pfc_fb_max #(.N(NCH), .W(DW)) u_fb (
        .bus_i({isw_b_i, isw_a_i}),
        .max_o(fb_c)
    );

    // Current error, one bit wider so no sample pair can overflow it.
    always_comb begin
        ref_x = EW'(iref_i);
        fb_x  = EW'(fb_c);
        err_c = ref_x - fb_x;
    end

    // Input stage: capture error and mains sample on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v  <= 1'b0;
            err_q <= '0;
            vin_q <= '0;
        end else begin
            s1_v <= start_ok;
            if (start_ok) begin
                err_q <= err_c;
                vin_q <= vin_i;
            end
        end
    end

    pfc_law_core #(.EW(EW), .DW(DW), .GW(GW), .ACC_W(ACC_W)) u_law (
        .clk(clk), .rst_n(rst_n),
        .in_vld_i(s1_v), .err_i(err_q), .vin_i(vin_q),
        .kp_i(kp_q), .ki_i(ki_q), .kff_i(kff_q),
        .integ_i(integ_q),
        .mid_vld_o(s2_v), .out_vld_o(s3_v),
        .sum_o(sum_q), .cand_o(cand_q)
    );

    pfc_duty_clamp #(
        .ACC_W(ACC_W), .GF(GF), .DUTY_W(DUTY_W), .DUTY_MAX(DUTY_MAX)
    ) u_clamp (
        .sum_i(sum_q), .duty_o(duty_c), .sat_o(sat_c)
    );

    // Output stage: publish duty, pulse valid, commit integrator unless clamped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_o     <= '0;
            duty_vld_o <= 1'b0;
            integ_q    <= '0;
        end else begin
            duty_vld_o <= s3_v;
            if (s3_v) begin
                duty_o <= duty_c;
                if (!sat_c) begin
                    integ_q <= cand_q;
                end
            end
        end
    end
endmodule

// File: rtl/pfc_cur_loop_chk.sv
// Checker: timing and bound properties of the current loop, bound to the top.
module pfc_cur_loop_chk #(
    parameter int DUTY_W   = 12,
    parameter int DUTY_MAX = 3276,
    parameter int GW       = 16,
    parameter int ACC_W    = 33
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic                    busy,
    input logic [DUTY_W-1:0]       duty_o,
    input logic                    duty_vld_o,
    input logic signed [ACC_W-1:0] integ_q,
    input logic signed [GW-1:0]    kp_q,
    input logic signed [GW-1:0]    ki_q,
    input logic signed [GW-1:0]    kff_q
);
    // R7: accepted start gives a result three edges later.
    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |-> ##4 duty_vld_o);

    // R7: valid is a single-cycle pulse.
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        duty_vld_o |=> !duty_vld_o);

    // R7: duty only moves together with a valid pulse.
    assert_duty_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !duty_vld_o |-> $stable(duty_o));

    // R4: published duty stays under the cap.
    assert_duty_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        duty_o <= DUTY_W'(DUTY_MAX));

    // R9: gains cannot change while a computation is in flight.
    assert_gain_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({kp_q, ki_q, kff_q}));

    // R3: the integrator only moves at a result.
    assert_integ_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !duty_vld_o |-> $stable(integ_q));
endmodule

bind pfc_cur_loop pfc_cur_loop_chk #(
    .DUTY_W(DUTY_W), .DUTY_MAX(DUTY_MAX), .GW(GW), .ACC_W(ACC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy(busy),
    .duty_o(duty_o), .duty_vld_o(duty_vld_o), .integ_q(integ_q),
    .kp_q(kp_q), .ki_q(ki_q), .kff_q(kff_q)
);

// File: tb/tb_pfc_cur_loop.sv
// Bench: grid sweep plus directed cases, with an arithmetic reference model.
module tb_pfc_cur_loop;
    localparam int DW = 12;
    localparam int GW = 16;
    localparam int DUTY_W = 12;
    localparam longint DMAX = 3276;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic signed [DW-1:0] isw_a_i = '0, isw_b_i = '0, iref_i = '0, vin_i = '0;
    logic cfg_we_i = 1'b0;
    logic [1:0] cfg_sel_i = '0;
    logic signed [GW-1:0] cfg_data_i = '0;
    logic [DUTY_W-1:0] duty_o;
    logic duty_vld_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    longint m_kp, m_ki, m_kff, m_integ;

    pfc_cur_loop dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .isw_a_i(isw_a_i), .isw_b_i(isw_b_i), .iref_i(iref_i), .vin_i(vin_i),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_data_i(cfg_data_i),
        .duty_o(duty_o), .duty_vld_o(duty_vld_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model of one computation; updates the model integrator.
    task automatic model(input longint a, input longint b, input longint r, input longint u,
                         output longint d, output string tag);
        longint fb, e, cand, s;
        fb = (a > b) ? a : b;
        e = r - fb;
        cand = m_integ + m_ki * e;
        s = m_kp * e + cand + m_kff * u;
        d = s >>> 8;
        if (d < 0) begin
            d = 0; tag = "R5";
        end else if (d > DMAX) begin
            d = DMAX; tag = "R4";
        end else begin
            m_integ = cand; tag = "R2";
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_kp = 960; m_ki = 64; m_kff = 128; m_integ = 0;
    endtask

    task automatic wr(input logic [1:0] sel, input longint val);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_data_i = GW'(val);
        @(negedge clk);
        cfg_we_i = 1'b0;
        if (sel == 2'd0) m_kp = val;
        if (sel == 2'd1) m_ki = val;
        if (sel == 2'd2) m_kff = val;
    endtask

    // One computation: checks latency (R7) and the duty against the model.
    task automatic run(input longint a, input longint b, input longint r, input longint u,
                       input string note);
        longint d;
        string tag;
        int cnt;
        @(negedge clk);
        isw_a_i = DW'(a); isw_b_i = DW'(b); iref_i = DW'(r); vin_i = DW'(u);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cnt = 1;
        while (!duty_vld_o && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
        model(a, b, r, u, d, tag);
        chk(cnt == 4, "R7 latency", cnt, 4);
        chk(duty_o == DUTY_W'(d), {tag, " ", note}, duty_o, d);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hang expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        longint cur [6] = '{-2048, -1, 0, 1, 500, 2047};
        longint refs [4] = '{-300, 0, 800, 2047};
        longint vins [3] = '{0, 1000, 2047};
        int pulses;
        longint d;
        string tag;

        do_reset();
        @(negedge clk);
        chk(duty_o == 0, "R10 duty after reset", duty_o, 0);
        chk(duty_vld_o == 1'b0, "R10 valid after reset", duty_vld_o, 0);
        // R10: defaults Kp=3.75 Ki=0.25 -> (96000+6400)>>8 = 400
        run(0, 0, 100, 0, "R10 default gains");
        chk(duty_o == 400, "R10 default value", duty_o, 400);

        // R1: larger channel wins, in either position, including negatives.
        do_reset();
        wr(2'd0, 256); wr(2'd1, 0); wr(2'd2, 0);
        run(200, 700, 1000, 0, "R1 b larger");
        chk(duty_o == 300, "R1 b larger", duty_o, 300);
        run(700, 200, 1000, 0, "R1 a larger");
        chk(duty_o == 300, "R1 a larger", duty_o, 300);
        run(-5, -100, 1000, 0, "R1 negatives");
        chk(duty_o == 1005, "R1 negatives", duty_o, 1005);

        // R3: integral only, constant error 40 -> +10 per computation.
        do_reset();
        wr(2'd0, 0); wr(2'd1, 64); wr(2'd2, 0);
        for (int k = 1; k <= 4; k++) begin
            run(0, 0, 40, 0, "R3 ramp");
            chk(duty_o == 10 * k, "R3 ramp step", duty_o, 10 * k);
        end

        // R6: drive into the cap, then back: integrator must not have wound.
        do_reset();
        wr(2'd0, 0); wr(2'd1, 256); wr(2'd2, 0);
        run(0, 0, 2000, 0, "R6 first");
        chk(duty_o == 2000, "R6 first", duty_o, 2000);
        run(0, 0, 2000, 0, "R6 capped");
        chk(duty_o == DMAX, "R4 cap value", duty_o, DMAX);
        run(0, 0, 2000, 0, "R6 still capped");
        run(0, 0, -100, 0, "R6 unwind");
        chk(duty_o == 1900, "R6 held integrator", duty_o, 1900);
        run(0, 0, -2047, 0, "R6 low side");
        chk(duty_o == 0, "R5 floor", duty_o, 0);
        run(0, 0, 50, 0, "R6 after low clamp");
        chk(duty_o == 1950, "R6 held at floor", duty_o, 1950);

        // R8: start held for two cycles yields one result.
        do_reset();
        @(negedge clk);
        isw_a_i = 0; isw_b_i = 0; iref_i = 100; vin_i = 0;
        start_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        start_i = 1'b0;
        pulses = 0;
        for (int k = 0; k < 10; k++) begin
            if (duty_vld_o) pulses++;
            @(negedge clk);
        end
        model(0, 0, 100, 0, d, tag);
        chk(pulses == 1, "R8 single result", pulses, 1);
        chk(duty_o == DUTY_W'(d), "R8 duty", duty_o, d);
        run(0, 0, 100, 0, "R8 integrator advanced once");

        // R9: writes during a computation or with start are dropped.
        do_reset();
        @(negedge clk);
        isw_a_i = 0; isw_b_i = 0; iref_i = 100; vin_i = 0;
        start_i = 1'b1; cfg_we_i = 1'b1; cfg_sel_i = 2'd0; cfg_data_i = 0;
        @(negedge clk);
        start_i = 1'b0; cfg_sel_i = 2'd2; cfg_data_i = 16'sd1000;
        @(negedge clk);
        cfg_we_i = 1'b0;
        repeat (4) @(negedge clk);
        model(0, 0, 100, 0, d, tag);
        chk(duty_o == DUTY_W'(d), "R9 write with start dropped", duty_o, d);
        run(0, 0, 100, 1000, "R9 gains unchanged after busy writes");
        wr(2'd3, 5);
        run(0, 0, 100, 1000, "R9 code 3 writes nothing");
        wr(2'd2, 256);
        run(0, 0, 100, 400, "R9 idle write applied");

        // Grid sweep over currents, set point and mains sample (R1,R2,R4,R5).
        do_reset();
        wr(2'd0, 200); wr(2'd1, 8); wr(2'd2, 128);
        foreach (cur[ia]) foreach (cur[ib]) foreach (refs[ir]) foreach (vins[iu])
            run(cur[ia], cur[ib], refs[ir], vins[iu], "sweep");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule